// File: doc/BRIEF.md
# Two-Level Carry Look-Ahead Adder

This block is a purely combinational 16-bit unsigned adder. It takes two 16-bit operands and a carry-in, and it returns a 16-bit sum and a carry-out. The carries are never passed from one bit to the next. Each bit first forms a generate term (both operand bits set) and a propagate term (the operand bits differ). Inside each 4-bit group, a sum-of-products network works out every internal carry directly from those terms and from the group's carry-in.

The operand is split into four such groups. Each group also reports a group generate and a group propagate. A second look-ahead stage of the same shape uses these four pairs and the adder's carry-in to work out the carry into every group at once. The block exposes the generate and propagate of the whole 16-bit span, so a wider adder can place this one under a further look-ahead stage. The carry-out is formed from that whole-span pair and the carry-in.

Top module: `cla16_adder`

## Requirements
- R1: For every combination of `a_i`, `b_i` and `c_i`, the 17-bit value {`c_o`, `sum_o`} equals `a_i` + `b_i` + `c_i` taken as unsigned integers.
- R2: `blk_prop_o` is 1 exactly when every bit position has differing operand bits, that is when `a_i` XOR `b_i` is all ones (`b_i` is the bitwise inverse of `a_i`).
- R3: `blk_gen_o` is 1 exactly when `a_i` + `b_i`, with no carry-in, is 65536 or more.
- R4: `c_o` equals `blk_gen_o` OR (`blk_prop_o` AND `c_i`).
- R5: `blk_gen_o` and `blk_prop_o` are never 1 at the same time.
- R6: `blk_gen_o` and `blk_prop_o` do not depend on `c_i`. For equal operands, toggling `c_i` leaves both unchanged.
- R7: When `blk_prop_o` is 1, a carry-in of 1 crosses all sixteen positions: `sum_o` is 0 and `c_o` is 1. With a carry-in of 0, `sum_o` is all ones and `c_o` is 0.
- R8: A carry that starts in one 4-bit group (bits 4k+3..4k) and crosses the group boundary changes the sum bits of the next group correctly. For example, 0x000F + 0x0001 gives 0x0010, and 0x0FFF + 0x0001 gives 0x1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand, unsigned |
| b_i | input | 16 | Second operand, unsigned |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Low 16 bits of a_i + b_i + c_i |
| c_o | output | 1 | Carry out of bit 15 |
| blk_gen_o | output | 1 | The whole 16-bit span produces a carry whatever the carry-in |
| blk_prop_o | output | 1 | The whole 16-bit span passes the carry-in through to the carry-out |

## Verification
The assertions are immediate checks that are evaluated whenever the inputs settle. They assume that the three inputs hold known 0/1 values, with no X or Z. They also assume that an input change is observed only after the combinational network has settled. The bench meets both assumptions: it drives every input from reset onward with fully defined values, and it changes the inputs only on the falling clock edge. It then samples the outputs just after the next rising edge, which is well clear of any change.

// File: rtl/cla_pkg.sv
package cla_pkg;

    localparam int CLA_DATA_W  = 16;
    localparam int CLA_GROUP_W = 4;
    localparam int CLA_MAX_W   = 32;

    typedef logic [CLA_MAX_W-1:0] cla_vec_t;

    // generate / propagate pair handed from one look-ahead level to the next
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Flat sum of products for the carry leaving position n-1 of a span.
    // The result is: OR over j of (g[j] AND every p above j), OR
    // (cin AND every p in the span). No carry feeds into a later term.
    function automatic logic span_carry(cla_vec_t g, cla_vec_t p, logic cin, int n);
        logic acc;
        logic prod;
        acc = 1'b0;
        for (int j = 0; j < CLA_MAX_W; j++) begin
            if (j < n) begin
                prod = g[j];
                for (int k = 0; k < CLA_MAX_W; k++) begin
                    if (k > j && k < n) prod = prod & p[k];
                end
                acc = acc | prod;
            end
        end
        prod = cin;
        for (int k = 0; k < CLA_MAX_W; k++) begin
            if (k < n) prod = prod & p[k];
        end
        return acc | prod;
    endfunction

    // AND of the propagate terms of the first n positions
    function automatic logic span_prop(cla_vec_t p, int n);
        logic prod;
        prod = 1'b1;
        for (int k = 0; k < CLA_MAX_W; k++) begin
            if (k < n) prod = prod & p[k];
        end
        return prod;
    endfunction

endpackage

// File: rtl/cla_bit_gp.sv
module cla_bit_gp #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] gen_o,
    output logic [W-1:0] prop_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign gen_o[i]  = a_i[i] & b_i[i];
        assign prop_o[i] = a_i[i] ^ b_i[i];
    end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead
    import cla_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0] gen_i,
    input  logic [N-1:0] prop_i,
    input  logic         c_i,
    output logic [N-1:0] carry_in_o,
    output gp_t          blk_o
);
    cla_vec_t g_ext;
    cla_vec_t p_ext;

    always_comb begin
        g_ext        = '0;
        p_ext        = '0;
        g_ext[N-1:0] = gen_i;
        p_ext[N-1:0] = prop_i;
    end

    assign carry_in_o[0] = c_i;

    // carry into position i is the carry leaving the span 0..i-1
    for (genvar i = 1; i < N; i++) begin : g_carry
        assign carry_in_o[i] = span_carry(g_ext, p_ext, c_i, i);
    end

    assign blk_o.g = span_carry(g_ext, p_ext, 1'b0, N);
    assign blk_o.p = span_prop(p_ext, N);
endmodule

// File: rtl/cla_group.sv
module cla_group
    import cla_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         c_i,
    output logic [W-1:0] sum_o,
    output gp_t          gp_o
);
    logic [W-1:0] bit_g;
    logic [W-1:0] bit_p;
    logic [W-1:0] bit_cin;

    cla_bit_gp #(.W(W)) u_gp (
        .a_i   (a_i),
        .b_i   (b_i),
        .gen_o (bit_g),
        .prop_o(bit_p)
    );

    cla_lookahead #(.N(W)) u_la (
        .gen_i     (bit_g),
        .prop_i    (bit_p),
        .c_i       (c_i),
        .carry_in_o(bit_cin),
        .blk_o     (gp_o)
    );

    assign sum_o = bit_p ^ bit_cin;
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
    import cla_pkg::*;
#(
    parameter int DATA_W  = CLA_DATA_W,
    parameter int GROUP_W = CLA_GROUP_W
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              c_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              c_o,
    output logic              blk_gen_o,
    output logic              blk_prop_o
);
    localparam int NGRP = DATA_W / GROUP_W;

    gp_t             grp_gp [NGRP];
    logic [NGRP-1:0] grp_g;
    logic [NGRP-1:0] grp_p;
    logic [NGRP-1:0] grp_cin;
    gp_t             blk;

    // first level: one look-ahead group per GROUP_W-bit slice
    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        cla_group #(.W(GROUP_W)) u_grp (
            .a_i  (a_i[k*GROUP_W +: GROUP_W]),
            .b_i  (b_i[k*GROUP_W +: GROUP_W]),
            .c_i  (grp_cin[k]),
            .sum_o(sum_o[k*GROUP_W +: GROUP_W]),
            .gp_o (grp_gp[k])
        );
        assign grp_g[k] = grp_gp[k].g;
        assign grp_p[k] = grp_gp[k].p;
    end

    // second level: carries into every group in parallel
    cla_lookahead #(.N(NGRP)) u_lvl2 (
        .gen_i     (grp_g),
        .prop_i    (grp_p),
        .c_i       (c_i),
        .carry_in_o(grp_cin),
        .blk_o     (blk)
    );

    assign blk_gen_o  = blk.g;
    assign blk_prop_o = blk.p;
    assign c_o        = blk.g | (blk.p & c_i);
endmodule

// File: rtl/cla16_adder_chk.sv
module cla16_adder_chk #(
    parameter int DATA_W = 16
) (
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic              c_i,
    input logic [DATA_W-1:0] sum_o,
    input logic              c_o,
    input logic              blk_gen_o,
    input logic              blk_prop_o
);
    logic [DATA_W:0] ref_full;
    logic [DATA_W:0] ref_nocin;

    always_comb begin
        ref_full  = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, c_i};
        ref_nocin = {1'b0, a_i} + {1'b0, b_i};
        p_sum_exact_r1: assert ({c_o, sum_o} == ref_full)
            else $error("R1 sum mismatch");
        p_blk_prop_r2: assert (blk_prop_o == ((a_i ^ b_i) == '1))
            else $error("R2 block propagate mismatch");
        p_blk_gen_r3: assert (blk_gen_o == ref_nocin[DATA_W])
            else $error("R3 block generate mismatch");
        p_cout_form_r4: assert (c_o == (blk_gen_o | (blk_prop_o & c_i)))
            else $error("R4 carry-out form mismatch");
        p_gp_excl_r5: assert (!(blk_gen_o && blk_prop_o))
            else $error("R5 generate and propagate both set");
        p_full_pass_r7: assert (!blk_prop_o || (c_i ? (sum_o == '0 && c_o) : (sum_o == '1 && !c_o)))
            else $error("R7 full-span pass mismatch");
    end
endmodule

bind cla16_adder cla16_adder_chk #(.DATA_W(DATA_W)) u_chk (
    .a_i       (a_i),
    .b_i       (b_i),
    .c_i       (c_i),
    .sum_o     (sum_o),
    .c_o       (c_o),
    .blk_gen_o (blk_gen_o),
    .blk_prop_o(blk_prop_o)
);

// File: tb/cla16_adder_bench.sv
module cla16_adder_bench;
    localparam int W = 16;
    localparam int NVEC = 12;
    localparam int NRAND = 3000;
    localparam int WD_LIMIT = 100000;

    // each entry: {a, b, cin}
    localparam logic [2*W:0] VEC [NVEC] = '{
        {16'h0000, 16'h0000, 1'b0},
        {16'h000B, 16'h0006, 1'b0},
        {16'hFFFF, 16'hFFFF, 1'b1},
        {16'hFFFF, 16'h0001, 1'b0},
        {16'h000F, 16'h0001, 1'b0},
        {16'h0FFF, 16'h0001, 1'b0},
        {16'h00FF, 16'h0000, 1'b1},
        {16'h8000, 16'h8000, 1'b0},
        {16'h1234, 16'hEDCB, 1'b1},
        {16'h1234, 16'hEDCB, 1'b0},
        {16'hA5A5, 16'h5A5B, 1'b0},
        {16'h7FFF, 16'h0000, 1'b1}
    };

    logic         clk;
    logic         rst;
    logic [W-1:0] a, b;
    logic         cin;
    logic [W-1:0] sum;
    logic         cout, bg, bp;
    int           checks = 0;
    int           errors = 0;
    int           cycles = 0;
    logic         done = 1'b0;

    cla16_adder u_cla16_adder (
        .a_i(a), .b_i(b), .c_i(cin),
        .sum_o(sum), .c_o(cout), .blk_gen_o(bg), .blk_prop_o(bp)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cycles <= 0;
        else     cycles <= cycles + 1;
    end

    initial begin
        wait (cycles >= WD_LIMIT);
        if (!done) begin
            errors = errors + 1;
            $display("FAIL watchdog: act %0d cycles exp < %0d", cycles, WD_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: act %0h exp %0h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
        @(negedge clk);
        a = va; b = vb; cin = vc;
        @(posedge clk);
        #2;
    endtask

    // expected values from the requirements, applied to the present inputs
    task automatic check_all(input string tag);
        logic [W:0] full, nocin;
        logic pexp, gexp;
        full  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        nocin = {1'b0, a} + {1'b0, b};
        pexp  = ((a ^ b) == '1);
        gexp  = nocin[W];
        chk({tag, " R1 sum"}, {15'd0, cout, sum}, {15'd0, full});
        chk({tag, " R2 prop"}, {31'd0, bp}, {31'd0, pexp});
        chk({tag, " R3 gen"}, {31'd0, bg}, {31'd0, gexp});
        chk({tag, " R4 cout"}, {31'd0, cout}, {31'd0, gexp | (pexp & cin)});
        chk({tag, " R5 excl"}, {31'd0, bg & bp}, 32'd0);
    endtask

    initial begin
        rst = 1'b1; a = '0; b = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #2;
        // idle state with all-zero inputs
        chk("R1 idle sum", {15'd0, cout, sum}, 32'd0);
        chk("R3 idle gen", {31'd0, bg}, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][2*W:W+1], VEC[i][W:1], VEC[i][0]);
            check_all("table");
        end

        for (int i = 0; i < NRAND; i++) begin
            apply(W'($urandom), W'($urandom), 1'($urandom));
            check_all("random");
        end

        // R6: toggle the carry-in with fixed operands
        for (int i = 0; i < 20; i++) begin
            logic [W-1:0] ra, rb;
            logic g0, p0;
            ra = W'($urandom);
            rb = (i % 2 == 0) ? ~ra : W'($urandom);
            apply(ra, rb, 1'b0);
            g0 = bg; p0 = bp;
            apply(ra, rb, 1'b1);
            chk("R6 gen vs cin", {31'd0, bg}, {31'd0, g0});
            chk("R6 prop vs cin", {31'd0, bp}, {31'd0, p0});
        end

        // R7: full-span pass with complementary operands
        apply(16'h3C96, 16'hC369, 1'b1);
        chk("R7 pass sum", {16'd0, sum}, 32'd0);
        chk("R7 pass cout", {31'd0, cout}, 32'd1);
        apply(16'h3C96, 16'hC369, 1'b0);
        chk("R7 hold sum", {16'd0, sum}, 32'h0000FFFF);
        chk("R7 hold cout", {31'd0, cout}, 32'd0);

        // R8: carries crossing each group boundary
        apply(16'h000F, 16'h0001, 1'b0);
        chk("R8 grp0->1", {16'd0, sum}, 32'h00000010);
        apply(16'h00FF, 16'h0000, 1'b1);
        chk("R8 grp1->2", {16'd0, sum}, 32'h00000100);
        apply(16'h0FFF, 16'h0001, 1'b0);
        chk("R8 grp2->3", {16'd0, sum}, 32'h00001000);
        apply(16'h0800, 16'h0800, 1'b0);
        chk("R8 gen grp2", {16'd0, sum}, 32'h00001000);
        for (int k = 0; k < 4; k++) begin
            logic [W-1:0] ta;
            ta = W'((32'd1 << (4 * k + 4)) - 1);
            apply(ta, 16'h0000, 1'b1);
            chk("R8 carry sweep", {15'd0, cout, sum}, {15'd0, {1'b0, ta} + 17'd1});
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule